// File: doc/BRIEF.md
# Two-Wire Bus Serial Clock Generator

This block produces the serial clock for the master side of a two-wire serial bus. A programmable prescaler first divides the functional clock down to an internal time base. The serial clock then alternates between a low phase and a high phase. Each phase lasts a programmed number of internal cycles plus a fixed offset of six. A single-cycle tick output marks every change of the serial clock, so that a byte engine can place data and sample bits on it.

Each timing register holds two 8-bit duration fields. The lower byte is the standard or fast duration, and the upper byte is the high-speed duration. In high-speed mode a transfer begins with standard timing, which covers the master-code phase. A one-cycle switch request then moves the generator to the upper-byte fields. The change is made at the next falling edge of the serial clock. Timing values are captured only at phase boundaries, so changing the registers in the middle of a phase cannot shorten or stretch a pulse that has already begun.

Top module: `scl_gen`

## Requirements
- R1: While `en` is low, `scl` stays 1 and `edge_tick` stays 0. The only exception is the single release cycle described in R10.
- R2: The first rising clock edge that samples `en` high drives `scl` to 0 and pulses `edge_tick`. The first phase is therefore a low phase.
- R3: The internal time base advances once every `presc`+1 functional clock cycles. A `presc` value of 0 gives one internal cycle per functional clock cycle.
- R4: A phase whose selected field holds the value F lasts exactly (F+6)×(`presc`+1) functional clock cycles.
- R5: When `hs_mode` is 0, the low phase uses `low_time[7:0]` and the high phase uses `high_time[7:0]`. Bits 15:8 of both registers have no effect on any phase length.
- R6: When `hs_mode` is 1 and no switch has been requested, the phases use the bits 7:0 fields. After the switch, low phases use `low_time[15:8]` and high phases use `high_time[15:8]`.
- R7: A one-cycle pulse on `hs_switch` while `hs_mode` is 1 takes effect at the next high-to-low boundary of `scl`. A high phase that is already running keeps its standard length.
- R8: Changes to `low_time`, `high_time` or `presc` in the middle of a phase leave the current phase length unchanged. The new values apply from the next boundary onward.
- R9: `edge_tick` is high for exactly one functional clock cycle. It is high in the same cycle in which `scl` shows its new value, and only then.
- R10: Dropping `en` returns `scl` to 1 on the next clock edge. If `scl` was low, `edge_tick` pulses once with that rise. A later enable restarts with standard timing, whatever switch was made before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable |
| hs_mode | input | 1 | Enables the two-phase high-speed timing |
| hs_switch | input | 1 | One-cycle request to move to high-speed fields |
| presc | input | PRESC_W | Prescaler value; divide ratio is presc+1 |
| low_time | input | 2*FIELD_W | Low-phase durations: standard in lower byte, high-speed in upper byte |
| high_time | input | 2*FIELD_W | High-phase durations, same packing |
| scl | output | 1 | Serial clock |
| edge_tick | output | 1 | One-cycle pulse on each serial clock change |

## Verification
The bench builds the block with its default 8-bit field and 8-bit prescaler widths. These widths put both extremes within reach. A prescaler value of 255 gives 1536- and 1792-cycle phases, and a field value of 255 with no division gives a 261-cycle phase. Random prescaler values and register contents, including random upper bytes with high-speed mode off, are mixed with directed runs. The directed runs cover the switch request arriving in a low phase and in a high phase, writes made in the middle of a phase, and disabling in the middle of a phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Fixed number of internal cycles added to every programmed field.
    localparam int PHASE_OFFSET = 6;

    // Defaults for the timing field and prescaler widths.
    localparam int DEF_FIELD_W = 8;
    localparam int DEF_PRESC_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_e;

endpackage

// File: rtl/scl_presc.sv
module scl_presc #(
    parameter int PRESC_W = scl_gen_pkg::DEF_PRESC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               load,
    input  logic [PRESC_W-1:0] presc_in,
    output logic               ick
);

    logic [PRESC_W-1:0] div_q;
    logic [PRESC_W-1:0] pcnt;

    assign ick = run && (pcnt == div_q);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt  <= '0;
            div_q <= presc_in;
        end else begin
            if (load) begin
                div_q <= presc_in;
            end
            if (pcnt == div_q) begin
                pcnt <= '0;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (pcnt <= div_q)); // R3

endmodule

// File: rtl/scl_phase.sv
module scl_phase
    import scl_gen_pkg::*;
#(
    parameter int FIELD_W = DEF_FIELD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 hs_mode,
    input  logic                 hs_switch,
    input  logic                 ick,
    input  logic [2*FIELD_W-1:0] low_time,
    input  logic [2*FIELD_W-1:0] high_time,
    output logic                 scl,
    output logic                 tick,
    output logic                 run,
    output logic                 load
);

    localparam int DUR_W = FIELD_W + 1;

    scl_state_e       st;
    logic [DUR_W-1:0] cnt;
    logic [DUR_W-1:0] dur;
    logic             hs_sel;
    logic             pend;
    logic             pend_n;
    logic             hs_next_low;
    logic             at_end;

    function automatic logic [DUR_W-1:0] phase_len(
        input logic [2*FIELD_W-1:0] packed_reg,
        input logic                 use_hs
    );
        logic [FIELD_W-1:0] f;
        f = use_hs ? packed_reg[2*FIELD_W-1:FIELD_W] : packed_reg[FIELD_W-1:0];
        return DUR_W'(f) + DUR_W'(PHASE_OFFSET);
    endfunction

    assign run         = (st != ST_IDLE);
    assign at_end      = run && ick && (cnt == dur - 1'b1);
    assign load        = at_end;
    assign pend_n      = hs_mode && (pend || hs_switch);
    assign hs_next_low = hs_mode && (hs_sel || pend_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            scl    <= 1'b1;
            tick   <= 1'b0;
            cnt    <= '0;
            dur    <= '0;
            hs_sel <= 1'b0;
            pend   <= 1'b0;
        end else if (!en) begin
            st     <= ST_IDLE;
            tick   <= run && !scl;
            scl    <= 1'b1;
            cnt    <= '0;
            hs_sel <= 1'b0;
            pend   <= 1'b0;
        end else begin
            tick <= 1'b0;
            pend <= pend_n;
            if (!hs_mode) begin
                hs_sel <= 1'b0;
            end
            unique case (st)
                ST_IDLE: begin
                    st   <= ST_LOW;
                    scl  <= 1'b0;
                    tick <= 1'b1;
                    cnt  <= '0;
                    dur  <= phase_len(low_time, 1'b0);
                end
                ST_LOW: begin
                    if (at_end) begin
                        st   <= ST_HIGH;
                        scl  <= 1'b1;
                        tick <= 1'b1;
                        cnt  <= '0;
                        dur  <= phase_len(high_time, hs_mode && hs_sel);
                    end else if (ick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (at_end) begin
                        st     <= ST_LOW;
                        scl    <= 1'b0;
                        tick   <= 1'b1;
                        cnt    <= '0;
                        hs_sel <= hs_next_low;
                        pend   <= 1'b0;
                        dur    <= phase_len(low_time, hs_next_low);
                    end else if (ick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !en |=> (scl && (st == ST_IDLE))); // R1

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < dur)); // R4

    AST_SWITCH_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_sel) |-> (!scl && $past(hs_mode))); // R7

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        (en && (st == ST_IDLE)) |=> (!scl && tick)); // R2

endmodule

// File: rtl/scl_gen.sv
module scl_gen
    import scl_gen_pkg::*;
#(
    parameter int FIELD_W = DEF_FIELD_W,
    parameter int PRESC_W = DEF_PRESC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 hs_mode,
    input  logic                 hs_switch,
    input  logic [PRESC_W-1:0]   presc,
    input  logic [2*FIELD_W-1:0] low_time,
    input  logic [2*FIELD_W-1:0] high_time,
    output logic                 scl,
    output logic                 edge_tick
);

    logic ick;
    logic run;
    logic load;

    scl_presc #(
        .PRESC_W (PRESC_W)
    ) i_presc (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .load     (load),
        .presc_in (presc),
        .ick      (ick)
    );

    scl_phase #(
        .FIELD_W (FIELD_W)
    ) i_phase (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .hs_mode   (hs_mode),
        .hs_switch (hs_switch),
        .ick       (ick),
        .low_time  (low_time),
        .high_time (high_time),
        .scl       (scl),
        .tick      (edge_tick),
        .run       (run),
        .load      (load)
    );

    AST_TICK_MEANS_EDGE: assert property (@(posedge clk) disable iff (rst)
        edge_tick |-> (scl != $past(scl))); // R9

    AST_EDGE_MEANS_TICK: assert property (@(posedge clk) disable iff (rst)
        (scl != $past(scl)) |-> edge_tick); // R9

endmodule

// File: tb/test_scl_gen.sv
`timescale 1ns/1ps
module test_scl_gen;

    localparam int FW = 8;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          hs_mode = 1'b0;
    logic          hs_switch = 1'b0;
    logic [PW-1:0] presc = '0;
    logic [2*FW-1:0] low_time = '0;
    logic [2*FW-1:0] high_time = '0;
    logic          scl;
    logic          edge_tick;

    int checks = 0;
    int errors = 0;

    scl_gen #(.FIELD_W(FW), .PRESC_W(PW)) i_scl_gen (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .hs_mode   (hs_mode),
        .hs_switch (hs_switch),
        .presc     (presc),
        .low_time  (low_time),
        .high_time (high_time),
        .scl       (scl),
        .edge_tick (edge_tick)
    );

    always #2 clk = ~clk;

    function automatic int plen(input int field, input int p);
        return (field + 6) * (p + 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic meas(input int chg_at, input logic [2*FW-1:0] nlo,
                        input logic [PW-1:0] nps, input bit sw,
                        output int len, output int lvl);
        lvl = int'(scl);
        len = 0;
        hs_switch = sw;
        do begin
            @(negedge clk);
            hs_switch = 1'b0;
            len++;
            if (chg_at != 0 && len == chg_at) begin
                low_time = nlo;
                presc = nps;
            end
        end while (!edge_tick && len < 20000);
    endtask

    task automatic phase(input string req, input int exp_lvl, input int exp_len, input bit sw);
        int len;
        int lvl;
        meas(0, low_time, presc, sw, len, lvl);
        chk({req, " level"}, lvl, exp_lvl);
        chk({req, " length"}, len, exp_len);
    endtask

    task automatic start_gen();
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk("R2 start scl", int'(scl), 0);
        chk("R2 start tick", int'(edge_tick), 1);
    endtask

    task automatic stop_gen();
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R10 release scl", int'(scl), 1);
        @(negedge clk);
        chk("R1 idle scl", int'(scl), 1);
        chk("R1 idle tick", int'(edge_tick), 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", checks, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len;
        int lvl;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 reset scl", int'(scl), 1);
        chk("R1 reset tick", int'(edge_tick), 0);

        // R3: undivided, minimum fields
        presc = 0; low_time = 16'h0000; high_time = 16'h0000;
        start_gen();
        phase("R3 undivided low", 0, 6, 0);
        phase("R3 undivided high", 1, 6, 0);
        stop_gen();

        // R3 / R4: maximum prescaler and maximum field
        presc = 8'd255; low_time = 16'h0000; high_time = 16'h0001;
        start_gen();
        phase("R3 max presc low", 0, plen(0, 255), 0);
        phase("R4 max presc high", 1, plen(1, 255), 0);
        stop_gen();
        presc = 0; low_time = 16'h00FF; high_time = 16'h0003;
        start_gen();
        phase("R4 max field low", 0, plen(255, 0), 0);
        stop_gen();

        // R4 / R5: random timing, random ignored upper bytes
        for (int it = 0; it < 12; it++) begin
            int p;
            p = int'($urandom_range(0, 3));
            presc = PW'(p);
            low_time = 16'($urandom);
            high_time = 16'($urandom);
            low_time[7:0] = 8'($urandom_range(0, 20));
            high_time[7:0] = 8'($urandom_range(0, 20));
            hs_mode = 1'b0;
            start_gen();
            phase("R5 low byte low", 0, plen(int'(low_time[7:0]), p), 0);
            phase("R5 low byte high", 1, plen(int'(high_time[7:0]), p), 0);
            phase("R4 second low", 0, plen(int'(low_time[7:0]), p), 0);
            stop_gen();
        end

        // R6 / R7: switch requested during a low phase
        presc = 0; hs_mode = 1'b1;
        low_time = {8'd2, 8'd10}; high_time = {8'd3, 8'd12};
        start_gen();
        phase("R6 std low", 0, 16, 0);
        phase("R6 std high", 1, 18, 0);
        phase("R7 low with request", 0, 16, 1);
        phase("R7 high keeps std", 1, 18, 0);
        phase("R6 hs low", 0, 8, 0);
        phase("R6 hs high", 1, 9, 0);
        phase("R6 hs low again", 0, 8, 0);
        stop_gen();

        // R10: re-enable restarts in standard timing; R7 request in high phase
        start_gen();
        phase("R10 restart std low", 0, 16, 0);
        phase("R7 high with request", 1, 18, 1);
        phase("R7 hs after fall", 0, 8, 0);
        stop_gen();

        // R10: disable in the middle of a low phase
        start_gen();
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R10 mid-phase rise scl", int'(scl), 1);
        chk("R10 mid-phase rise tick", int'(edge_tick), 1);
        @(negedge clk);
        chk("R1 after release tick", int'(edge_tick), 0);
        hs_mode = 1'b0;

        // R8: writes in the middle of a phase
        presc = 8'd1; low_time = 16'd10; high_time = 16'd4;
        start_gen();
        meas(5, 16'd2, 8'd0, 0, len, lvl);
        chk("R8 current low unchanged", len, plen(10, 1));
        phase("R8 high uses new presc", 1, plen(4, 0), 0);
        phase("R8 low uses new field", 0, plen(2, 0), 0);
        stop_gen();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule